// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Generator

This block turns a peripheral clock into the bit timing of two independent serial channels. Each channel holds an 8-bit divisor N and a 2-bit prescale code n. The code picks a power-of-four prescale of 1, 4, 16 or 64. The divisor then stretches the bit period by a factor of N+1. A per-channel framing input selects asynchronous or synchronous operation, and that choice changes the overall ratio by a factor of eight.

In asynchronous framing a channel emits an oversampling strobe sixteen times per bit, for the receiver's sampling logic. It also emits a bit strobe on every sixteenth oversampling strobe. In synchronous framing the channel drives a square serial clock whose period is one bit. The bit strobe marks each rising edge of that clock. Software writes and reads the settings through a simple register port. Any write to a channel restarts that channel's timing from a clean phase. A standby input returns both divisors to their maximum value, and a global enable freezes all timing.

Top module: `bitrate_gen`

## Requirements
- R1: After reset, each channel's divisor reads 0xFF and its prescale code reads 0. Any divisor value from 0 to 255 can be stored.
- R2: While `standby` is high, both divisors become 0xFF on the next clock edge, even when a divisor write arrives in the same cycle. The prescale codes keep their values.
- R3: With `wr_en` high, `wr_reg`=0 writes `wr_data` to the divisor of channel `wr_ch`, and `wr_reg`=1 writes `wr_data[1:0]` to its prescale code. `rd_data` shows the register selected by `rd_ch`/`rd_reg` with the same encoding, and a prescale code reads back zero-extended. A write to one channel leaves the other channel's registers unchanged.
- R4: In asynchronous framing (`mode_sync`=0), consecutive `bit_tick` pulses are 32·4^n·(N+1) clock cycles apart.
- R5: In asynchronous framing, `os_tick` pulses are 2·4^n·(N+1) cycles apart. `bit_tick` is high together with every 16th `os_tick`, counted from a restart, and with no other.
- R6: In synchronous framing (`mode_sync`=1), consecutive `bit_tick` pulses are 4·4^n·(N+1) cycles apart, and `os_tick` stays low.
- R7: In synchronous framing, `sclk` is high for 2·4^n·(N+1) cycles and then low for the same number of cycles. `bit_tick` is high in the first cycle of each high phase. In asynchronous framing, `sclk` stays low.
- R8: A register write to a channel clears that channel's counters at the write edge. The channel's first strobe (`os_tick` in asynchronous framing, `bit_tick` in synchronous framing) follows exactly 2·4^n·(N+1) cycles after that edge.
- R9: While `enable` is low, no strobe fires and `sclk` is low. After `enable` rises, the first strobe follows 2·4^n·(N+1) cycles after the last disabled edge.
- R10: The two channels run simultaneously at different rates, each set only by its own registers and framing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs all timing when high; holds counters at zero when low |
| standby | input | 1 | Forces both divisors to 0xFF and restarts both channels |
| mode_sync | input | 2 | Per-channel framing: 0 asynchronous, 1 synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by a write |
| wr_reg | input | 1 | Register addressed by a write: 0 divisor, 1 prescale code |
| wr_data | input | 8 | Write data |
| rd_ch | input | 1 | Channel addressed by the read port |
| rd_reg | input | 1 | Register addressed by the read port: 0 divisor, 1 prescale code |
| rd_data | output | 8 | Read data from the addressed register |
| bit_tick | output | 2 | Per-channel one-cycle bit strobe |
| os_tick | output | 2 | Per-channel one-cycle oversampling strobe (asynchronous framing) |
| sclk | output | 2 | Per-channel serial clock (synchronous framing) |

## Verification
The bench builds the block with its default parameters: two channels, an 8-bit divisor, a 2-bit prescale code and sixteen oversampling strobes per bit. With these values every prescale code can be reached. Small divisors keep even the 64× prescale within a few thousand cycles per bit, so the bench times exact intervals under all four codes in both framings. It also drives the two channels at unequal rates together, and checks the collision between a standby pulse and a divisor write.

// File: rtl/brg_pkg.sv
package brg_pkg;

    // Register selector on the software port; the encoding is visible to software.
    typedef enum logic {
        REG_DIVISOR = 1'b0,
        REG_CLKSEL  = 1'b1
    } brg_reg_e;

    // Per-channel framing selector.
    typedef enum logic {
        FRAME_ASYNC = 1'b0,
        FRAME_SYNC  = 1'b1
    } brg_frame_e;

    function automatic int unsigned brg_ch_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import brg_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned SEL_W  = 2,
    localparam int unsigned CH_W  = brg_ch_width(NUM_CH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            standby,
    input  logic                            wr_en,
    input  logic [CH_W-1:0]                 wr_ch,
    input  logic                            wr_reg,
    input  logic [DIV_W-1:0]                wr_data,
    input  logic [CH_W-1:0]                 rd_ch,
    input  logic                            rd_reg,
    output logic [DIV_W-1:0]                rd_data,
    output logic [NUM_CH-1:0][DIV_W-1:0]    div_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]    sel_o,
    output logic [NUM_CH-1:0]               restart_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][DIV_W-1:0] div;
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_CH-1:0] restart_d;

    always_comb begin
        regs_d    = regs_q;
        restart_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en && (wr_ch == CH_W'(c))) begin
                restart_d[c] = 1'b1;
                if (wr_reg == REG_DIVISOR) begin
                    regs_d.div[c] = wr_data;
                end else begin
                    regs_d.sel[c] = wr_data[SEL_W-1:0];
                end
            end
            // Standby wins over a write in the same cycle.
            if (standby) begin
                regs_d.div[c] = '1;
                restart_d[c]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.div <= '1;
            regs_q.sel <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        if (rd_reg == REG_DIVISOR) begin
            rd_data = regs_q.div[rd_ch];
        end else begin
            rd_data = DIV_W'(regs_q.sel[rd_ch]);
        end
    end

    assign div_o     = regs_q.div;
    assign sel_o     = regs_q.sel;
    assign restart_o = restart_d;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: standby saturates the divisor on the following edge.
        assert_standby_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
            standby |=> (regs_q.div[c] == '1));

        // R2: standby leaves the prescale code alone.
        assert_standby_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (standby && !(wr_en && wr_ch == CH_W'(c) && wr_reg == REG_CLKSEL))
            |=> $stable(regs_q.sel[c]));

        // R3: a divisor write lands in the addressed channel.
        assert_div_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !standby && wr_ch == CH_W'(c) && wr_reg == REG_DIVISOR)
            |=> (regs_q.div[c] == $past(wr_data)));

        // R3: other channels are untouched by a write.
        assert_other_ch_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !standby && wr_ch != CH_W'(c))
            |=> ($stable(regs_q.div[c]) && $stable(regs_q.sel[c])));
    end

endmodule

// File: rtl/brg_chan.sv
module brg_chan
    import brg_pkg::*;
#(
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned OS_PER_BIT = 16,
    localparam int unsigned PRE_W     = 2 * ((1 << SEL_W) - 1) + 1,
    localparam int unsigned PH_W      = (OS_PER_BIT > 1) ? $clog2(OS_PER_BIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             mode,
    input  logic [DIV_W-1:0] div,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_tick,
    output logic             os_tick,
    output logic             sclk
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] cnt;
        logic [PH_W-1:0]  phase;
        logic             sclk;
        logic             bit_tick;
        logic             os_tick;
    } chan_t;

    chan_t st_d, st_q;
    logic [PRE_W-1:0] pre_lim;
    logic             pre_wrap;
    logic             unit_tick;

    // Prescale span is 2*4^sel clocks: one half of a synchronous bit
    // at N=0, or one oversampling slot at N=0.
    function automatic logic [PRE_W-1:0] span_limit(input logic [SEL_W-1:0] s);
        logic [PRE_W:0] one;
        one = 1;
        return PRE_W'((one << (2 * s + 1)) - 1'b1);
    endfunction

    assign pre_lim   = span_limit(sel);
    assign pre_wrap  = (st_q.pre == pre_lim);
    assign unit_tick = pre_wrap && (st_q.cnt == div);

    always_comb begin
        st_d          = st_q;
        st_d.bit_tick = 1'b0;
        st_d.os_tick  = 1'b0;
        if (!enable || restart) begin
            st_d = '0;
        end else begin
            st_d.pre = pre_wrap ? '0 : st_q.pre + 1'b1;
            if (pre_wrap) begin
                st_d.cnt = unit_tick ? '0 : st_q.cnt + 1'b1;
            end
            if (mode == FRAME_SYNC) begin
                st_d.phase = '0;
                if (unit_tick) begin
                    st_d.sclk     = ~st_q.sclk;
                    st_d.bit_tick = ~st_q.sclk;
                end
            end else begin
                st_d.sclk = 1'b0;
                if (unit_tick) begin
                    st_d.os_tick  = 1'b1;
                    st_d.bit_tick = (st_q.phase == PH_W'(OS_PER_BIT - 1));
                    st_d.phase    = (st_q.phase == PH_W'(OS_PER_BIT - 1)) ?
                                    '0 : st_q.phase + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_tick = st_q.bit_tick;
    assign os_tick  = st_q.os_tick;
    assign sclk     = st_q.sclk;

    // R9: a disabled cycle leaves every output quiet afterwards.
    assert_quiet_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bit_tick && !os_tick && !sclk));

    // R5: an asynchronous bit strobe always rides on an oversampling strobe.
    assert_bit_on_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && $past(mode) == FRAME_ASYNC) |-> os_tick);

    // R7: a synchronous bit strobe marks a rising serial clock.
    assert_sync_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && $past(mode) == FRAME_SYNC) |-> $rose(sclk));

    // R6: no oversampling strobe in synchronous framing.
    assert_no_os_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == FRAME_SYNC) |-> !os_tick);

    // R8: the divisor counter never passes the programmed divisor.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= div);

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
    import brg_pkg::*;
#(
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned OS_PER_BIT = 16,
    localparam int unsigned CH_W      = brg_ch_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              standby,
    input  logic [NUM_CH-1:0] mode_sync,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_reg,
    input  logic [DIV_W-1:0]  wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    input  logic              rd_reg,
    output logic [DIV_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] bit_tick,
    output logic [NUM_CH-1:0] os_tick,
    output logic [NUM_CH-1:0] sclk
);

    logic [NUM_CH-1:0][DIV_W-1:0] div;
    logic [NUM_CH-1:0][SEL_W-1:0] sel;
    logic [NUM_CH-1:0]            restart;

    brg_regs #(
        .NUM_CH (NUM_CH),
        .DIV_W  (DIV_W),
        .SEL_W  (SEL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_reg    (wr_reg),
        .wr_data   (wr_data),
        .rd_ch     (rd_ch),
        .rd_reg    (rd_reg),
        .rd_data   (rd_data),
        .div_o     (div),
        .sel_o     (sel),
        .restart_o (restart)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        brg_chan #(
            .DIV_W      (DIV_W),
            .SEL_W      (SEL_W),
            .OS_PER_BIT (OS_PER_BIT)
        ) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (enable),
            .restart  (restart[c]),
            .mode     (mode_sync[c]),
            .div      (div[c]),
            .sel      (sel[c]),
            .bit_tick (bit_tick[c]),
            .os_tick  (os_tick[c]),
            .sclk     (sclk[c])
        );
    end

endmodule

// File: tb/bitrate_gen_tb_top.sv
module bitrate_gen_tb_top;
    import brg_pkg::*;

    localparam int NUM_CH = 2;
    localparam int DIV_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enable;
    logic             standby;
    logic [1:0]       mode_sync;
    logic             wr_en;
    logic [0:0]       wr_ch;
    logic             wr_reg;
    logic [7:0]       wr_data;
    logic [0:0]       rd_ch;
    logic             rd_reg;
    logic [7:0]       rd_data;
    logic [1:0]       bit_tick;
    logic [1:0]       os_tick;
    logic [1:0]       sclk;

    longint cyc = 0;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bitrate_gen #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .standby(standby),
        .mode_sync(mode_sync), .wr_en(wr_en), .wr_ch(wr_ch), .wr_reg(wr_reg),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_reg(rd_reg), .rd_data(rd_data),
        .bit_tick(bit_tick), .os_tick(os_tick), .sclk(sclk)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint unit_len(input int n, input int dv);
        return (longint'(2) << (2 * n)) * longint'(dv + 1);
    endfunction

    function automatic logic probe(input int ch, input int kind);
        case (kind)
            0:       return bit_tick[ch];
            1:       return os_tick[ch];
            default: return sclk[ch];
        endcase
    endfunction

    task automatic wait_evt(input int ch, input int kind, output longint t);
        do @(negedge clk); while (!probe(ch, kind));
        t = cyc;
    endtask

    task automatic write_reg(input int ch, input logic r, input logic [7:0] v,
                             output longint w);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 1'(ch); wr_reg = r; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        w = cyc;
    endtask

    task automatic read_reg(input int ch, input logic r, output logic [7:0] v);
        @(negedge clk);
        rd_ch = 1'(ch); rd_reg = r;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            read_reg(ch, 1'b0, v);
            check("R1", $sformatf("ch%0d divisor after reset", ch), v, 8'hFF);
            read_reg(ch, 1'b1, v);
            check("R1", $sformatf("ch%0d code after reset", ch), v, 0);
        end
    endtask

    task automatic t_async(input int ch, input int n, input int dv);
        longint w, t, prev, first, tb;
        longint u;
        int bad_gap, bad_bit;
        u = unit_len(n, dv);
        @(negedge clk);
        mode_sync[ch] = 1'b0;
        write_reg(ch, 1'b1, 8'(n), w);
        write_reg(ch, 1'b0, 8'(dv), w);
        wait_evt(ch, 1, first);
        check("R8", $sformatf("async ch%0d n%0d N%0d first os delay", ch, n, dv), first - w, u);
        prev = first; bad_gap = 0; bad_bit = 0;
        if (bit_tick[ch]) bad_bit++;
        for (int k = 2; k <= 16; k++) begin
            wait_evt(ch, 1, t);
            if (t - prev != u) bad_gap++;
            if (k < 16 && bit_tick[ch]) bad_bit++;
            if (k == 16) check("R5", "bit tick on 16th os tick", bit_tick[ch], 1);
            if (sclk[ch]) bad_bit++;
            prev = t;
        end
        check("R5", "os tick spacing mismatches", bad_gap, 0);
        check("R5", "bit tick off the 16th os tick or sclk high (R7)", bad_bit, 0);
        check("R4", "first bit period from restart", prev - w, 16 * u);
        wait_evt(ch, 0, tb);
        check("R4", $sformatf("async ch%0d n%0d N%0d bit period", ch, n, dv), tb - prev, 16 * u);
    endtask

    task automatic t_sync(input int ch, input int n, input int dv);
        longint w, t1, u;
        int high, bits, oss;
        u = unit_len(n, dv);
        @(negedge clk);
        mode_sync[ch] = 1'b1;
        write_reg(ch, 1'b1, 8'(n), w);
        write_reg(ch, 1'b0, 8'(dv), w);
        wait_evt(ch, 0, t1);
        check("R8", $sformatf("sync ch%0d n%0d N%0d first bit delay", ch, n, dv), t1 - w, u);
        check("R7", "sclk high on bit tick", sclk[ch], 1);
        high = 1; bits = 0; oss = int'(os_tick[ch]);
        for (longint i = 1; i < 2 * u; i++) begin
            @(negedge clk);
            high += int'(sclk[ch]);
            bits += int'(bit_tick[ch]);
            oss  += int'(os_tick[ch]);
        end
        @(negedge clk);
        check("R7", "sclk high cycles per period", high, u);
        check("R6", $sformatf("sync ch%0d n%0d N%0d bit tick after one period", ch, n, dv),
              bit_tick[ch], 1);
        check("R6", "extra bit ticks within period", bits, 0);
        check("R6", "os ticks in sync framing", oss, 0);
    endtask

    task automatic t_standby();
        longint w;
        logic [7:0] v;
        write_reg(0, 1'b0, 8'd5, w);
        write_reg(1, 1'b1, 8'd2, w);
        write_reg(1, 1'b0, 8'd7, w);
        @(negedge clk);
        standby = 1'b1; wr_en = 1'b1; wr_ch = 1'b0; wr_reg = 1'b0; wr_data = 8'd3;
        @(negedge clk);
        standby = 1'b0; wr_en = 1'b0;
        read_reg(0, 1'b0, v);
        check("R2", "ch0 divisor after standby with write", v, 8'hFF);
        read_reg(1, 1'b0, v);
        check("R2", "ch1 divisor after standby", v, 8'hFF);
        read_reg(1, 1'b1, v);
        check("R2", "ch1 code kept over standby", v, 2);
    endtask

    task automatic t_two();
        longint w, a, b;
        logic [7:0] v;
        @(negedge clk);
        mode_sync = 2'b10;
        write_reg(0, 1'b1, 8'd0, w);
        write_reg(0, 1'b0, 8'd1, w);
        write_reg(1, 1'b1, 8'd1, w);
        write_reg(1, 1'b0, 8'd0, w);
        read_reg(0, 1'b0, v);
        check("R3", "ch0 divisor kept after ch1 writes", v, 1);
        read_reg(1, 1'b1, v);
        check("R3", "ch1 code zero-extended", v, 1);
        wait_evt(0, 0, a);
        wait_evt(0, 0, b);
        check("R10", "ch0 async bit period with ch1 running", b - a, 64);
        wait_evt(1, 0, a);
        wait_evt(1, 0, b);
        check("R10", "ch1 sync bit period with ch0 running", b - a, 16);
    endtask

    task automatic t_enable();
        longint w, c, t;
        int seen;
        @(negedge clk);
        mode_sync = 2'b11;
        write_reg(0, 1'b1, 8'd0, w);
        write_reg(0, 1'b0, 8'd1, w);
        @(negedge clk);
        enable = 1'b0;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (i > 0) seen += $countones({bit_tick, os_tick, sclk});
        end
        check("R9", "outputs active while disabled", seen, 0);
        enable = 1'b1;
        c = cyc;
        wait_evt(0, 0, t);
        check("R9", "first bit tick after enable", t - c, unit_len(0, 1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; standby = 1'b0; mode_sync = 2'b00;
        wr_en = 1'b0; wr_ch = 1'b0; wr_reg = 1'b0; wr_data = '0;
        rd_ch = 1'b0; rd_reg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_async(0, 0, 0);
        t_async(1, 1, 3);
        t_async(0, 3, 1);
        t_async(1, 2, 2);
        t_sync(1, 0, 0);
        t_sync(0, 2, 2);
        t_sync(1, 3, 0);
        t_sync(0, 1, 255);
        t_standby();
        t_two();
        t_enable();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule